// File: doc/BRIEF.md
# Binary Dot-Product Unit (XNOR and Population Count)

This block computes the scaled dot product of two vectors whose elements are each +1 or -1. Both vectors arrive packed, one bit per element, one word of each per accepted beat. For every word the block compares the weight bits with the activation bits, discards the positions above that word's valid-element count, and counts the positions that agree. The counts are summed across the words of a vector. When the word flagged as last has passed through, the agreement count becomes a signed dot product. That product is multiplied by two unsigned fixed-point scale factors, rounded and saturated.

The input side is a valid/ready stream: a word is taken on a rising edge where `in_valid` and `in_ready` are both high. The output side is a valid/ready stream that carries one result per vector. The whole pipeline advances together, and it halts only when a result is waiting and `out_ready` is low. In that case `in_ready` falls, and every stage holds its contents until the result is taken. A producer may keep `in_valid` asserted through a stall. The word it presents is taken on the first edge where `in_ready` is high again. Results leave in the order their vectors arrived.

Top module: `bin_dot_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: A bit value of 1 stands for +1 and 0 stands for -1. Element i of a word is bit i. The dot product of a vector is the sum of weight times activation over its valid elements, which equals twice the number of agreeing positions minus the number of valid elements.
- R3: Only bits 0 to `in_nbits`-1 of a word take part, with `in_nbits` ranging from 0 to WORD_W. Bits at or above that count have no effect on the result. A word with `in_nbits` = 0 adds nothing.
- R4: A vector is the run of accepted words that ends with a word carrying `in_last` = 1. The next accepted word starts a fresh vector. Vectors, including single-word vectors, may follow one another with no idle cycle.
- R5: `in_alpha` and `in_beta` are taken together with the last word of a vector. Each is an unsigned fixed-point value with FRAC_W fraction bits (with the defaults, 256 means 1.0). The result is floor(dot * alpha * beta / 2^(2*FRAC_W) + 1/2), so exact halves round toward plus infinity.
- R6: A result outside the signed OUT_W range saturates to -2^(OUT_W-1) or 2^(OUT_W-1)-1.
- R7: With `out_ready` held high, `out_valid` is high for exactly one cycle per vector, log2(WORD_W)+2 rising edges after the edge that accepted the vector's last word, and is low in every other cycle. Results appear in vector order.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged.
- R9: `in_ready` is low exactly while a result is waiting and is not being taken. A word is accepted only on an edge where `in_valid` and `in_ready` are both high. Stalls never lose or repeat a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_weight | input | WORD_W | Packed weight bits |
| in_act | input | WORD_W | Packed activation bits |
| in_nbits | input | $clog2(WORD_W+1) | Number of valid low-order elements in this word |
| in_last | input | 1 | Word closes the current vector |
| in_alpha | input | SCALE_W | Weight scale factor, read with the last word |
| in_beta | input | SCALE_W | Activation scale factor, read with the last word |
| out_valid | output | 1 | Scaled result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | OUT_W | Signed, rounded and saturated scaled dot product |

## Verification
The result of a vector is due log2(WORD_W)+2 = 8 rising edges after the edge that accepted its last word. The reference model in the bench tags each expected value with that due cycle. During the phase where `out_ready` stays high, the bench checks at every falling edge that `out_valid` is high in exactly the due cycle and low in all others. It compares the value in that cycle. In the back-pressure phase, timing is no longer fixed. The bench then checks that values come out in order, that a stalled result holds from one falling edge to the next, and that `in_ready` is low during each stall.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  // default geometry shared by the unit and its bench
  localparam int unsigned DEF_WORD_W  = 64;
  localparam int unsigned DEF_SCALE_W = 16;
  localparam int unsigned DEF_FRAC_W  = 8;
  localparam int unsigned DEF_ACC_W   = 16;
  localparam int unsigned DEF_OUT_W   = 24;

  // width of a count that must represent 0..n inclusive
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bdp_xnor_mask.sv
module bdp_xnor_mask #(
  parameter int unsigned W    = 64,
  parameter int unsigned NB_W = 7,
  parameter int unsigned SB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            in_vld,
  input  logic [W-1:0]    in_w,
  input  logic [W-1:0]    in_a,
  input  logic [NB_W-1:0] in_nbits,
  input  logic [SB_W-1:0] in_sb,
  output logic            out_vld,
  output logic [W-1:0]    out_bits,
  output logic [SB_W-1:0] out_sb
);
  logic [W-1:0] keep;
  logic [W-1:0] agree;

  // one comparator per lane: lane i survives when it lies below the count
  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep[i] = (in_nbits > NB_W'(i));
  end

  assign agree = ~(in_w ^ in_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_bits <= '0;
      out_sb   <= '0;
    end else if (en) begin
      out_vld  <= in_vld;
      out_bits <= agree & keep;
      out_sb   <= in_sb;
    end
  end
endmodule

// File: rtl/bdp_pop_tree.sv
module bdp_pop_tree #(
  parameter  int unsigned W    = 64,
  parameter  int unsigned SB_W = 8,
  localparam int unsigned LV   = $clog2(W),
  localparam int unsigned CW   = LV + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            in_vld,
  input  logic [W-1:0]    in_bits,
  input  logic [SB_W-1:0] in_sb,
  output logic            out_vld,
  output logic [CW-1:0]   out_cnt,
  output logic [SB_W-1:0] out_sb
);
  // heap layout: node k sums children 2k and 2k+1; leaves sit at W..2W-1
  logic [CW-1:0]   node [1:W-1];
  logic [CW-1:0]   full [1:2*W-1];
  logic [LV-1:0]   vld_d;
  logic [SB_W-1:0] sb_d [0:LV-1];

  always_comb begin
    for (int k = 1; k < W; k++) full[k] = node[k];
    for (int i = 0; i < W; i++) full[W+i] = CW'(in_bits[i]);
  end

  // every tree level is one register stage
  always_ff @(posedge clk) begin
    if (en) begin
      for (int k = 1; k < W; k++) node[k] <= full[2*k] + full[2*k+1];
    end
  end

  // sideband travels level by level beside the sums
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_d <= '0;
    end else if (en) begin
      vld_d[0] <= in_vld;
      for (int s = 1; s < LV; s++) vld_d[s] <= vld_d[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sb_d[0] <= in_sb;
      for (int s = 1; s < LV; s++) sb_d[s] <= sb_d[s-1];
    end
  end

  assign out_vld = vld_d[LV-1];
  assign out_cnt = node[1];
  assign out_sb  = sb_d[LV-1];
endmodule

// File: rtl/bdp_accum.sv
module bdp_accum #(
  parameter  int unsigned CW    = 7,
  parameter  int unsigned NB_W  = 7,
  parameter  int unsigned ACC_W = 16,
  parameter  int unsigned SC_W  = 32,
  localparam int unsigned DW    = ACC_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_vld,
  input  logic                 in_last,
  input  logic [CW-1:0]        in_cnt,
  input  logic [NB_W-1:0]      in_nbits,
  input  logic [SC_W-1:0]      in_scale,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_dot,
  output logic [SC_W-1:0]      out_scale
);
  logic             first_q;
  logic [ACC_W-1:0] agree_q, total_q;
  logic [ACC_W-1:0] agree_n, total_n;
  logic signed [DW-1:0] dot_n;

  // a word that opens a vector ignores the previous totals
  always_comb begin
    agree_n = (first_q ? '0 : agree_q) + ACC_W'(in_cnt);
    total_n = (first_q ? '0 : total_q) + ACC_W'(in_nbits);
    dot_n   = $signed({1'b0, agree_n, 1'b0}) - $signed({2'b00, total_n});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= 1'b1;
      agree_q   <= '0;
      total_q   <= '0;
      out_vld   <= 1'b0;
      out_dot   <= '0;
      out_scale <= '0;
    end else if (en) begin
      out_vld <= in_vld && in_last;
      if (in_vld) begin
        agree_q <= agree_n;
        total_q <= total_n;
        first_q <= in_last;
      end
      if (in_vld && in_last) begin
        out_dot   <= dot_n;
        out_scale <= in_scale;
      end
    end
  end
endmodule

// File: rtl/bdp_scale_sat.sv
module bdp_scale_sat #(
  parameter  int unsigned DW      = 18,
  parameter  int unsigned SCALE_W = 16,
  parameter  int unsigned FRAC_W  = 8,
  parameter  int unsigned OUT_W   = 24,
  localparam int unsigned PW      = DW + 2*SCALE_W + 1,
  localparam int unsigned SH      = 2*FRAC_W,
  localparam int unsigned SHM     = (SH > 0) ? SH - 1 : 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_dot,
  input  logic [SCALE_W-1:0]   in_alpha,
  input  logic [SCALE_W-1:0]   in_beta,
  output logic                 out_vld,
  output logic [OUT_W-1:0]     out_res
);
  localparam logic signed [PW-1:0] HALF = (SH > 0) ? (PW'(1) << SHM) : '0;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) << (OUT_W-1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic [2*SCALE_W-1:0] ab;
  logic signed [PW-1:0] dot_x, ab_x, prod, rnd, shf;
  logic [OUT_W-1:0]     res_n;

  always_comb begin
    ab    = {SCALE_W'(0), in_alpha} * {SCALE_W'(0), in_beta};
    dot_x = PW'(in_dot);
    ab_x  = $signed(PW'(ab));
    prod  = dot_x * ab_x;
    rnd   = prod + HALF;
    shf   = rnd >>> SH;
    if (shf > MAXV)      res_n = MAXV[OUT_W-1:0];
    else if (shf < MINV) res_n = MINV[OUT_W-1:0];
    else                 res_n = shf[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
    end else if (en) begin
      out_vld <= in_vld;
      if (in_vld) out_res <= res_n;
    end
  end
endmodule

// File: rtl/bin_dot_unit.sv
module bin_dot_unit #(
  parameter  int unsigned WORD_W  = bdp_pkg::DEF_WORD_W,
  parameter  int unsigned SCALE_W = bdp_pkg::DEF_SCALE_W,
  parameter  int unsigned FRAC_W  = bdp_pkg::DEF_FRAC_W,
  parameter  int unsigned ACC_W   = bdp_pkg::DEF_ACC_W,
  parameter  int unsigned OUT_W   = bdp_pkg::DEF_OUT_W,
  localparam int unsigned NB_W    = bdp_pkg::count_width(WORD_W),
  localparam int unsigned SC_W    = 2*SCALE_W,
  localparam int unsigned SB_W    = 1 + NB_W + SC_W,
  localparam int unsigned CW      = $clog2(WORD_W) + 1,
  localparam int unsigned DW      = ACC_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_weight,
  input  logic [WORD_W-1:0]  in_act,
  input  logic [NB_W-1:0]    in_nbits,
  input  logic               in_last,
  input  logic [SCALE_W-1:0] in_alpha,
  input  logic [SCALE_W-1:0] in_beta,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_result
);
  logic              adv;
  logic [SB_W-1:0]   sb_in;
  logic              s0_vld;
  logic [WORD_W-1:0] s0_bits;
  logic [SB_W-1:0]   s0_sb;
  logic              tr_vld;
  logic [CW-1:0]     tr_cnt;
  logic [SB_W-1:0]   tr_sb;
  logic              tr_last;
  logic              dot_vld;
  logic signed [DW-1:0] dot_val;
  logic [SC_W-1:0]   dot_scale;

  // single stall domain: everything moves unless a held result blocks
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign sb_in    = {in_last, in_nbits, in_alpha, in_beta};
  assign tr_last  = tr_sb[SB_W-1];

  bdp_xnor_mask #(.W(WORD_W), .NB_W(NB_W), .SB_W(SB_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_vld(in_valid),
    .in_w(in_weight), .in_a(in_act), .in_nbits(in_nbits), .in_sb(sb_in),
    .out_vld(s0_vld), .out_bits(s0_bits), .out_sb(s0_sb)
  );

  bdp_pop_tree #(.W(WORD_W), .SB_W(SB_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_vld(s0_vld),
    .in_bits(s0_bits), .in_sb(s0_sb),
    .out_vld(tr_vld), .out_cnt(tr_cnt), .out_sb(tr_sb)
  );

  bdp_accum #(.CW(CW), .NB_W(NB_W), .ACC_W(ACC_W), .SC_W(SC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_vld(tr_vld), .in_last(tr_last),
    .in_cnt(tr_cnt), .in_nbits(tr_sb[SC_W +: NB_W]), .in_scale(tr_sb[SC_W-1:0]),
    .out_vld(dot_vld), .out_dot(dot_val), .out_scale(dot_scale)
  );

  bdp_scale_sat #(.DW(DW), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_vld(dot_vld), .in_dot(dot_val),
    .in_alpha(dot_scale[SC_W-1 -: SCALE_W]), .in_beta(dot_scale[SCALE_W-1:0]),
    .out_vld(out_valid), .out_res(out_result)
  );
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
  parameter int unsigned W     = 64,
  parameter int unsigned NB_W  = 7,
  parameter int unsigned SB_W  = 40,
  parameter int unsigned SC_W  = 32,
  parameter int unsigned OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_result,
  input logic             s0_vld,
  input logic [W-1:0]     s0_bits,
  input logic [SB_W-1:0]  s0_sb,
  input logic             tr_vld,
  input logic             tr_last,
  input logic             dot_vld,
  input logic             adv
);
  logic [NB_W-1:0] s0_nb;
  assign s0_nb = s0_sb[SC_W +: NB_W];

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_lanes_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s0_vld |-> ((s0_bits >> s0_nb) == '0));

  assert_last_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_vld && tr_last && adv) |=> dot_vld);

  assert_mid_word_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_vld && !tr_last && adv) |=> !dot_vld);

  assert_result_issued_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_vld && adv) |=> out_valid);

  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_no_take_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind bin_dot_unit bdp_checker #(
  .W(WORD_W), .NB_W(NB_W), .SB_W(SB_W), .SC_W(SC_W), .OUT_W(OUT_W)
) i_bdp_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .s0_vld(s0_vld),
  .s0_bits(s0_bits), .s0_sb(s0_sb), .tr_vld(tr_vld), .tr_last(tr_last),
  .dot_vld(dot_vld), .adv(adv)
);

// File: tb/test_bin_dot_unit.sv
module test_bin_dot_unit;
  localparam int W = 64, NB_W = 7, SCALE_W = 16, FRAC_W = 8, ACC_W = 16, OUT_W = 24;
  localparam int LAT = $clog2(W) + 2;
  localparam int ONE = 1 << FRAC_W;
  localparam longint SMAX = (longint'(1) << (OUT_W-1)) - 1;
  localparam longint SMIN = -SMAX - 1;

  logic clk = 0, rst_n = 0, in_valid = 0, in_last = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic [W-1:0] in_weight = '0, in_act = '0;
  logic [NB_W-1:0] in_nbits = '0;
  logic [SCALE_W-1:0] in_alpha = '0, in_beta = '0;
  logic [OUT_W-1:0] out_result;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit strict = 1, bp_on = 0, mon_on = 0, prev_stall = 0;
  logic [OUT_W-1:0] prev_res = '0;
  longint acc_dot = 0;
  longint q_val[$];
  int q_due[$];
  string q_tag[$];

  bin_dot_unit #(.WORD_W(W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .OUT_W(OUT_W))
  i_bin_dot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_weight(in_weight), .in_act(in_act), .in_nbits(in_nbits), .in_last(in_last),
    .in_alpha(in_alpha), .in_beta(in_beta), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint ref_scale(input longint dot, input longint al, input longint be);
    longint p, r;
    p = dot * al * be;
    r = (p + (longint'(1) << (2*FRAC_W - 1))) >>> (2*FRAC_W);
    if (r > SMAX) r = SMAX;
    if (r < SMIN) r = SMIN;
    return r;
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send_word(input logic [W-1:0] w, input logic [W-1:0] a, input int nb,
                           input bit last, input int al, input int be, input string tag);
    in_weight = w; in_act = a; in_nbits = NB_W'(nb); in_last = last;
    in_alpha = 16'(al); in_beta = 16'(be); in_valid = 1;
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < nb; i++) acc_dot += longint'((w[i] ? 1 : -1) * (a[i] ? 1 : -1));
    if (last) begin
      q_val.push_back(ref_scale(acc_dot, al, be));
      q_due.push_back(cyc + 1 + LAT);
      q_tag.push_back(tag);
      acc_dot = 0;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [W-1:0] rword();
    return {$urandom, $urandom};
  endfunction

  task automatic rand_vector(input string tag);
    int nw;
    nw = $urandom_range(1, 4);
    for (int j = 0; j < nw; j++)
      send_word(rword(), rword(), (j == nw-1) ? $urandom_range(1, W) : W, j == nw-1,
                $urandom_range(0, 65535), $urandom_range(0, 65535), tag);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    bit due;
    if (mon_on) begin
      if (prev_stall)
        chk(out_valid === 1'b1 && out_result === prev_res, "R8 stalled result held",
            longint'($signed(out_result)), longint'($signed(prev_res)));
      if (out_valid && !out_ready)
        chk(!in_ready, "R9 in_ready low while result waits", longint'(in_ready), 0);
      if (strict) begin
        due = q_due.size() > 0 && q_due[0] == cyc;
        chk(out_valid == due, "R7 out_valid in due cycle only", longint'(out_valid), longint'(due));
      end
      if (out_valid && out_ready) begin
        if (q_val.size() == 0) chk(1'b0, "R7 result with no vector", 1, 0);
        else begin
          chk(longint'($signed(out_result)) == q_val[0], q_tag[0],
              longint'($signed(out_result)), q_val[0]);
          void'(q_val.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res   = out_result;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 200000);
    report();
  end

  initial begin
    logic [W-1:0] w;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid low in reset", longint'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready high in reset", longint'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid low after reset", longint'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready high after reset", longint'(in_ready), 1);
    mon_on = 1;

    // R2: encoding and dot product
    send_word(rword(), rword(), W, 1, ONE, ONE, "R2 random full word");
    w = rword();
    send_word(w, w, W, 1, ONE, ONE, "R2 all agree gives +W");
    send_word(w, ~w, W, 1, ONE, ONE, "R2 all differ gives -W");
    // R3: masked lanes and empty words
    send_word('0, 64'hFFFF_FFFF_FFFF_FFE0, 5, 1, ONE, ONE, "R3 high lanes ignored");
    send_word(w, w, W, 0, 0, 0, "R3 empty word");
    send_word(w, ~w, 0, 0, 0, 0, "R3 empty word");
    send_word(w, w, W, 1, ONE, ONE, "R3 empty word adds nothing");
    // R4: multi-word vector, then back-to-back single words
    send_word(rword(), rword(), W, 0, 0, 0, "R4 multi-word vector");
    send_word(rword(), rword(), W, 0, 0, 0, "R4 multi-word vector");
    send_word(rword(), rword(), 10, 1, 3*ONE/2, ONE, "R4 multi-word vector");
    for (int v = 0; v < 4; v++)
      send_word(rword(), rword(), $urandom_range(1, W), 1, ONE, 2*ONE, "R4 back-to-back vector");
    // R5: rounding of halves
    send_word(64'h0, 64'h1, 1, 1, ONE/2, ONE, "R5 -0.5 rounds to 0");
    send_word(64'h7, 64'h7, 3, 1, ONE/2, ONE, "R5 1.5 rounds to 2");
    send_word(rword(), rword(), W, 1, 3*ONE/2, ONE/2, "R5 fractional scales");
    // R6: saturation both ways
    for (int j = 0; j < 3; j++) send_word(w, w, W, j == 2, 65535, 65535, "R6 positive saturation");
    for (int j = 0; j < 3; j++) send_word(w, ~w, W, j == 2, 65535, 65535, "R6 negative saturation");
    for (int v = 0; v < 6; v++) rand_vector("R4 random vector");
    repeat (LAT + 3) @(negedge clk);
    chk(q_val.size() == 0, "R7 every vector produced a result", q_val.size(), 0);

    // R8 and R9: random back-pressure
    strict = 0; bp_on = 1;
    for (int v = 0; v < 10; v++) rand_vector("R9 vector under back-pressure");
    while (q_val.size() > 0) @(negedge clk);
    bp_on = 0;
    repeat (LAT + 3) @(negedge clk);
    chk(q_val.size() == 0, "R9 no word lost under stalls", q_val.size(), 0);
    chk(out_valid == 0, "R7 no extra result after drain", longint'(out_valid), 0);
    report();
  end
endmodule